// File: doc/BRIEF.md
# Page Write Collector with In-Page Wrap

This block sits between a serial memory's bus engine and its nonvolatile array. During a write transaction the bus engine hands it a starting byte address, then one strobe per received data byte, then a stop indication. The block gathers the bytes into a 16-entry page buffer. Each entry has its own valid flag. When the stop arrives, it replays every valid entry to the array through a burst write port, one entry per clock. It then holds a busy flag for a programmable number of clocks to stand in for the internal programming time. While busy is high it ignores every input.

The address pointer moves only within the page. Its low four bits count up by one per data byte and wrap from 15 back to 0, and its upper bits never change during a transaction. A master that sends more than sixteen bytes therefore overwrites the bytes it sent earlier and never spills into the next page. Page slots that received no byte keep their old array contents. A per-byte allow input carries the protection decision, which is made outside the block.

The controller has four states. `PW_IDLE` waits for an address load. `PW_FILL` collects bytes. `PW_BURST` scans the sixteen buffer slots and drives the array port. `PW_HOLD` times the programming window. The transitions are as follows:
- IDLE→FILL on an address load.
- FILL→FILL on another address load, which restarts the transaction and discards what was collected.
- FILL→BURST on a stop when at least one entry is valid.
- FILL→IDLE on a stop when no entry is valid.
- BURST→HOLD after the last slot has been scanned.
- HOLD→IDLE when the hold timer expires, which also clears every valid flag.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy is 0, the array write enable is 0 and the address pointer is 0.
- R2: An accepted byte strobe in FILL advances the pointer's low PAGE_W bits by one modulo 16 and leaves the upper bits unchanged. The byte goes to the buffer slot named by the low bits before the advance.
- R3: When more than 16 bytes arrive before the stop, the slot index wraps. For each slot, the last byte stored there is the one programmed.
- R4: The array write enable is never asserted before a stop has been seen in FILL. A stop with at least one valid entry raises busy on the next clock.
- R5: Only valid slots are written, each exactly once, at address {pointer upper bits, slot}. All other array locations keep their contents.
- R6: Busy stays high for exactly 16 + HOLD_CYCLES consecutive clocks and then falls. Every valid flag is cleared at the same moment, so the next transaction programs only its own bytes.
- R7: A stop when no slot is valid (zero data bytes, or every byte refused) does not raise busy and writes nothing.
- R8: An address load in FILL discards all bytes collected so far and reloads the pointer. This covers a new start without a preceding stop.
- R9: While busy is high, address loads, byte strobes and stops have no effect on the pointer, the buffer or the busy duration.
- R10: A byte strobe with wr_allow low stores nothing, but it still advances the pointer.
- R11: A stop in IDLE has no effect.
- R12: Priority within one clock in FILL is address load, then stop, then byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load starting byte address and open a transaction |
| addr_in | input | ADDR_W | Starting byte address |
| byte_stb | input | 1 | One received data byte is present |
| byte_in | input | 8 | Data byte |
| wr_allow | input | 1 | Protection decision for the byte at the current pointer |
| stop_stb | input | 1 | Stop condition seen on the bus |
| busy | output | 1 | Internal write cycle in progress |
| ptr_addr | output | ADDR_W | Current byte address pointer |
| arr_we | output | 1 | Array write enable, one byte per clock |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with an 8-bit address, 16-byte pages and a hold time of 5 clocks. The short hold keeps each write cycle to 21 clocks, so the bench can run well over a hundred complete transactions. These sweep every length from 0 to 20 bytes from starting addresses at the start, middle and end of pages, including the top page, and half of them refuse some bytes through the allow input. A full 256-byte copy of the array is kept in the bench and compared after every transaction. That comparison exposes wrap overwrites, writes to slots that received nothing, and valid flags that survive from an earlier transaction. Directed cases cover inputs applied during busy, a restart without a stop, and a stop in idle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        PW_IDLE,
        PW_FILL,
        PW_BURST,
        PW_HOLD
    } pwb_state_e;
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0]  slot_vld;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = wr && (wr_idx == PAGE_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_vld[g]  <= 1'b0;
                slot_data[g] <= '0;
            end else if (clr) begin
                slot_vld[g]  <= 1'b0;
            end else if (hit) begin
                slot_vld[g]  <= 1'b1;
                slot_data[g] <= wr_data;
            end
        end
    end

    assign rd_data   = slot_data[rd_idx];
    assign rd_valid  = slot_vld[rd_idx];
    assign any_valid = |slot_vld;
endmodule

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    logic [PAGE_W-1:0] low_next;

    assign low_next = ptr[PAGE_W-1:0] + PAGE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_addr;
        end else if (step) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], low_next};
        end
    end
endmodule

// File: rtl/pwb_hold_timer.sv
module pwb_hold_timer #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int HOLD_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    input  logic              wr_allow,
    input  logic              stop_stb,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    localparam int DEPTH = 1 << PAGE_W;

    pwb_state_e        state, state_nx;
    logic [PAGE_W-1:0] scan_idx;
    logic              scan_last;
    logic              hold_done;
    logic              store_clr, store_wr, ptr_load, ptr_step;
    logic              any_valid, rd_valid;
    logic [7:0]        rd_data;
    logic              in_fill, take_byte;

    assign in_fill   = (state == PW_FILL);
    assign scan_last = (scan_idx == PAGE_W'(DEPTH - 1));
    assign take_byte = in_fill && byte_stb && !addr_load && !stop_stb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PW_IDLE:  if (addr_load) state_nx = PW_FILL;
            PW_FILL: begin
                if (addr_load)      state_nx = PW_FILL;
                else if (stop_stb)  state_nx = any_valid ? PW_BURST : PW_IDLE;
            end
            PW_BURST: if (scan_last) state_nx = PW_HOLD;
            PW_HOLD:  if (hold_done) state_nx = PW_IDLE;
            default:  state_nx = PW_IDLE;
        endcase
    end

    // scan counter for the burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx <= '0;
        end else if (state == PW_BURST) begin
            scan_idx <= scan_idx + PAGE_W'(1);
        end else begin
            scan_idx <= '0;
        end
    end

    // outputs and controls
    always_comb begin
        busy      = 1'b0;
        store_clr = 1'b0;
        store_wr  = 1'b0;
        ptr_load  = 1'b0;
        ptr_step  = 1'b0;
        arr_we    = 1'b0;
        unique case (state)
            PW_IDLE: begin
                ptr_load  = addr_load;
                store_clr = addr_load;
            end
            PW_FILL: begin
                ptr_load  = addr_load;
                store_clr = addr_load;
                ptr_step  = take_byte;
                store_wr  = take_byte && wr_allow;
            end
            PW_BURST: begin
                busy   = 1'b1;
                arr_we = rd_valid;
            end
            PW_HOLD: begin
                busy      = 1'b1;
                store_clr = hold_done;
            end
            default: ;
        endcase
    end

    assign arr_addr  = {ptr_addr[ADDR_W-1:PAGE_W], scan_idx};
    assign arr_wdata = rd_data;

    pwb_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_addr (addr_in),
        .step      (ptr_step),
        .ptr       (ptr_addr)
    );

    pwb_page_store #(.PAGE_W(PAGE_W), .DATA_W(8)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (store_clr),
        .wr        (store_wr),
        .wr_idx    (ptr_addr[PAGE_W-1:0]),
        .wr_data   (byte_in),
        .rd_idx    (scan_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pwb_hold_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == PW_HOLD),
        .done  (hold_done)
    );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int HOLD_CYCLES = 2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              addr_load,
    input logic              byte_stb,
    input logic              stop_stb,
    input logic              in_fill,
    input logic              any_valid
);
    localparam int TOTAL = (1 << PAGE_W) + HOLD_CYCLES;
    localparam int RW    = $clog2(TOTAL + 2);

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_cnt <= '0;
        else if (busy)   run_cnt <= run_cnt + RW'(1);
        else             run_cnt <= '0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !arr_we));

    a_r2_low_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && byte_stb && !addr_load && !stop_stb) |=>
        (ptr_addr[ADDR_W-1:PAGE_W] == $past(ptr_addr[ADDR_W-1:PAGE_W])) &&
        (ptr_addr[PAGE_W-1:0] == $past(ptr_addr[PAGE_W-1:0]) + PAGE_W'(1)));

    a_r4_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    a_r4_stop_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && stop_stb && !addr_load && any_valid) |=> busy);

    a_r5_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_addr[ADDR_W-1:PAGE_W] == ptr_addr[ADDR_W-1:PAGE_W]));

    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_cnt != '0) |-> (run_cnt == RW'(TOTAL)));

    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < RW'(TOTAL)));

    a_r7_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fill && stop_stb && !addr_load && !any_valid) |=> !busy);

    a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_addr));
endmodule

bind page_write_buffer pwb_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HOLD_CYCLES(HOLD_CYCLES)
) u_pwb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .ptr_addr  (ptr_addr),
    .addr_load (addr_load),
    .byte_stb  (byte_stb),
    .stop_stb  (stop_stb),
    .in_fill   (in_fill),
    .any_valid (any_valid)
);

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
    localparam int AW   = 8;
    localparam int PW   = 4;
    localparam int HOLD = 5;
    localparam int PG   = 1 << PW;
    localparam int MEMN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_stb = 1'b0;
    logic [7:0]    byte_in = '0;
    logic          wr_allow = 1'b0;
    logic          stop_stb = 1'b0;
    logic          busy, arr_we;
    logic [AW-1:0] ptr_addr, arr_addr;
    logic [7:0]    arr_wdata;

    always #2.5 clk = ~clk;

    page_write_buffer #(.ADDR_W(AW), .PAGE_W(PW), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .wr_allow(wr_allow),
        .stop_stb(stop_stb), .busy(busy), .ptr_addr(ptr_addr),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [MEMN];
    logic [7:0] exp_mem [MEMN];
    logic [7:0] pdata [PG];
    logic       pvld [PG];
    logic [AW-1:0] eptr;
    int busy_cnt, wr_cnt, oop_cnt, early_cnt;
    logic stopped;
    logic [AW-PW-1:0] cur_page;
    int cycles = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (arr_we) begin
            wr_cnt++;
            mem[arr_addr] = arr_wdata;
            if (arr_addr[AW-1:PW] != cur_page) oop_cnt++;
            if (!stopped) early_cnt++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    task automatic clr_counts();
        busy_cnt = 0; wr_cnt = 0; oop_cnt = 0; early_cnt = 0;
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
        if (!busy) begin
            eptr = a;
            for (int i = 0; i < PG; i++) pvld[i] = 1'b0;
        end
    endtask

    task automatic do_byte(input logic [7:0] d, input logic al);
        logic was_busy;
        @(negedge clk); was_busy = busy; byte_stb = 1'b1; byte_in = d; wr_allow = al;
        @(negedge clk); byte_stb = 1'b0;
        if (!was_busy) begin
            if (al) begin
                pdata[eptr[PW-1:0]] = d;
                pvld[eptr[PW-1:0]] = 1'b1;
            end
            eptr = {eptr[AW-1:PW], eptr[PW-1:0] + PW'(1)};
        end
    endtask

    // returns number of valid slots committed by the model
    task automatic do_stop(output int nv);
        logic was_busy;
        nv = 0;
        @(negedge clk); was_busy = busy; stop_stb = 1'b1; stopped = 1'b1;
        @(negedge clk); stop_stb = 1'b0;
        if (!was_busy) begin
            for (int i = 0; i < PG; i++) begin
                if (pvld[i]) begin
                    nv++;
                    exp_mem[{eptr[AW-1:PW], PW'(i)}] = pdata[i];
                end
                pvld[i] = 1'b0;
            end
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 1000) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    function automatic int mem_diffs();
        int d = 0;
        for (int i = 0; i < MEMN; i++) if (mem[i] !== exp_mem[i]) d++;
        return d;
    endfunction

    task automatic txn_checks(input int nv, input string tag);
        int eb;
        eb = (nv > 0) ? PG + HOLD : 0;
        chk(busy_cnt == eb, {tag, " R6 R7 busy length"}, busy_cnt, eb);
        chk(wr_cnt == nv, {tag, " R5 write count"}, wr_cnt, nv);
        chk(oop_cnt == 0, {tag, " R5 in-page"}, oop_cnt, 0);
        chk(early_cnt == 0, {tag, " R4 no write before stop"}, early_cnt, 0);
        chk(mem_diffs() == 0, {tag, " R3 R5 array contents"}, mem_diffs(), 0);
        chk(ptr_addr == eptr, {tag, " R2 R10 pointer"}, int'(ptr_addr), int'(eptr));
    endtask

    function automatic logic [AW-1:0] start_of(input int s);
        case (s)
            0: return 8'h00;
            1: return 8'h05;
            2: return 8'h0F;
            3: return 8'h3A;
            4: return 8'hF7;
            default: return 8'hFF;
        endcase
    endfunction

    initial begin
        int nv;
        for (int i = 0; i < MEMN; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        for (int i = 0; i < PG; i++) begin pvld[i] = 1'b0; pdata[i] = 8'h00; end
        eptr = '0; stopped = 1'b0; cur_page = '0;
        clr_counts();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
        chk(ptr_addr == '0, "R1 ptr", int'(ptr_addr), 0);

        // R11 stop in idle
        clr_counts(); stopped = 1'b1;
        do_stop(nv);
        wait_idle();
        txn_checks(0, "R11 idle stop");

        // sweep: R2 R3 R5 R6 R7 R10
        for (int s = 0; s < 6; s++) begin
            for (int n = 0; n <= 20; n++) begin
                logic [AW-1:0] st;
                st = start_of(s);
                cur_page = st[AW-1:PW];
                clr_counts(); stopped = 1'b0;
                do_load(st);
                for (int i = 0; i < n; i++) begin
                    logic al;
                    al = !((s % 2 == 1) && ((i + n) % 5 == 2));
                    do_byte(8'(st + 8'(i * 37) + 8'(n * 11) + 8'(s)), al);
                end
                do_stop(nv);
                wait_idle();
                txn_checks(nv, "sweep");
            end
        end

        // R8 restart without stop: first bytes discarded
        cur_page = 4'h4;
        clr_counts(); stopped = 1'b0;
        do_load(8'h42);
        do_byte(8'hA1, 1'b1); do_byte(8'hA2, 1'b1); do_byte(8'hA3, 1'b1);
        do_load(8'h49);
        do_byte(8'h5C, 1'b1);
        do_stop(nv);
        wait_idle();
        chk(nv == 1, "R8 model count", nv, 1);
        txn_checks(nv, "R8 restart");

        // R9 inputs during busy ignored
        cur_page = 4'h7;
        clr_counts(); stopped = 1'b0;
        do_load(8'h70);
        do_byte(8'h11, 1'b1); do_byte(8'h22, 1'b1);
        do_stop(nv);
        begin
            int dummy;
            @(negedge clk);
            do_load(8'h93);
            do_byte(8'hEE, 1'b1);
            do_stop(dummy);
        end
        wait_idle();
        txn_checks(nv, "R9 busy ignore");

        // R12 stop wins over simultaneous byte
        cur_page = 4'h2;
        clr_counts(); stopped = 1'b0;
        do_load(8'h20);
        do_byte(8'h77, 1'b1);
        @(negedge clk); stop_stb = 1'b1; byte_stb = 1'b1; byte_in = 8'h99; wr_allow = 1'b1; stopped = 1'b1;
        @(negedge clk); stop_stb = 1'b0; byte_stb = 1'b0;
        exp_mem[8'h20] = 8'h77; pvld[0] = 1'b0;
        wait_idle();
        txn_checks(1, "R12 priority");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule